// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This block sits beside the execute stage of a five-stage in-order pipeline. In the same cycle, it compares the two source register numbers of the instruction in execute with the destination registers of the two older instructions further down the pipe. The older instructions are the one holding its ALU result in the memory-stage register and the one about to write back. When a source matches a pending write, the block steers the ALU operand multiplexer to the newer copy of the value instead of the stale register file copy.

A value coming from a load exists only after data memory has been read. A load followed directly by an instruction that consumes its result therefore cannot be bypassed in time. For this case the block looks one stage earlier. It compares the load's destination, held in the decode/execute register, with the sources of the instruction still in decode, and raises a stall request for that cycle. An instruction three slots behind its producer needs no help, because the register file writes early in the cycle and reads late in the cycle.

Top module: `hazard_bypass_unit`

## Requirements
- R1: When the memory-stage producer has its write enable set, a nonzero destination, and a destination equal to an execute source, that operand's select is 2'b10.
- R2: When only the write-back-stage producer matches a source (write enable set, nonzero destination), that operand's select is 2'b01.
- R3: When both producers match the same source, the select is 2'b10, so the younger result wins. The code 2'b11 is never produced.
- R4: A source equal to register 0 always yields select 2'b00, whatever the producers hold.
- R5: A producer whose write enable is clear never causes forwarding, even if its destination matches.
- R6: When no producer matches, the select is 2'b00, meaning the register file value is used.
- R7: The two operand selects are computed independently. Each one depends only on its own source number.
- R8: stall_req is 1 when the decode/execute instruction is a load (load flag set) and its destination equals either decode-stage source.
- R9: stall_req is 0 when the load flag is clear, whatever the register numbers are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_AW | First source register of the instruction in execute |
| ex_src_b | input | REG_AW | Second source register of the instruction in execute |
| mem_dst | input | REG_AW | Destination of the instruction in the memory stage |
| mem_wen | input | 1 | Register write enable of the memory-stage instruction |
| wb_dst | input | REG_AW | Destination of the instruction in write-back |
| wb_wen | input | 1 | Register write enable of the write-back instruction |
| dx_dst | input | REG_AW | Destination held in the decode/execute register |
| dx_is_load | input | 1 | Decode/execute instruction reads data memory |
| dec_src_a | input | REG_AW | First source of the instruction in decode |
| dec_src_b | input | REG_AW | Second source of the instruction in decode |
| fwd_sel_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back |
| fwd_sel_b | output | 2 | Operand B select, same encoding |
| stall_req | output | 1 | Hold decode and fetch for one cycle |

## Verification
The bench builds the unit with a register number width of 3 instead of the default 5. Each source and destination then has only eight values, so random vectors collide often. This makes double matches, register-0 cases and load-use matches on both decode sources frequent rather than rare. Directed tasks cover each priority and each exclusion first. A seeded sweep then compares both selects and the stall against a model computed from the requirements.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } bypass_sel_e;
endpackage

// File: rtl/bypass_src_sel.sv
module bypass_src_sel
  import bypass_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  output bypass_sel_e       sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic hit_mem, hit_wb;

  // A producer qualifies only if it writes and does not target register 0.
  assign hit_mem = mem_wen && (mem_dst != ZERO_REG) && (mem_dst == src);
  assign hit_wb  = wb_wen  && (wb_dst  != ZERO_REG) && (wb_dst  == src);

  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_REGFILE;
  end

  always_comb begin
    assert_sel_legal_R3: assert (sel != 2'b11);
    assert_zero_src_R4: assert (!(src == ZERO_REG) || sel == SEL_REGFILE);
    assert_wb_origin_R2: assert (!(sel == SEL_WB) || (wb_wen && wb_dst == src && !(mem_wen && mem_dst == src)));
    assert_mem_origin_R5: assert (!(sel == SEL_MEM) || mem_wen);
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_AW = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] dec_src,
  input  logic [REG_AW-1:0]              dx_dst,
  input  logic                           dx_is_load,
  output logic                           stall_req
);
  logic [NUM_SRC-1:0] src_hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign src_hit[i] = (dec_src[i] == dx_dst);
  end

  assign stall_req = dx_is_load && (|src_hit);

  always_comb begin
    assert_stall_needs_load_R9: assert (!stall_req || dx_is_load);
    assert_stall_on_match_R8: assert (!(dx_is_load && dec_src[0] == dx_dst) || stall_req);
  end
endmodule

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit
  import bypass_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  input  logic [REG_AW-1:0] dx_dst,
  input  logic              dx_is_load,
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic              stall_req
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_AW-1:0] ex_src;
  logic [NUM_SRC-1:0][REG_AW-1:0] dec_src;
  bypass_sel_e                    sel [NUM_SRC];

  assign ex_src  = {ex_src_b, ex_src_a};
  assign dec_src = {dec_src_b, dec_src_a};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_operand
    bypass_src_sel #(.REG_AW(REG_AW)) u_sel (
      .src     (ex_src[i]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (sel[i])
    );
  end

  load_use_detect #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_lud (
    .dec_src    (dec_src),
    .dx_dst     (dx_dst),
    .dx_is_load (dx_is_load),
    .stall_req  (stall_req)
  );

  assign fwd_sel_a = sel[0];
  assign fwd_sel_b = sel[1];

  always_comb begin
    assert_same_src_same_sel_R7: assert (!(ex_src_a == ex_src_b) || fwd_sel_a == fwd_sel_b);
  end
endmodule

// File: tb/hazard_bypass_unit_tb.sv
module hazard_bypass_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst, dx_dst, dec_src_a, dec_src_b;
  logic mem_wen, wb_wen, dx_is_load;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic stall_req;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  hazard_bypass_unit #(.REG_AW(AW)) dut_i (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .mem_dst(mem_dst), .mem_wen(mem_wen),
    .wb_dst(wb_dst), .wb_wen(wb_wen),
    .dx_dst(dx_dst), .dx_is_load(dx_is_load),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .stall_req(stall_req)
  );

  function automatic logic [1:0] model_sel(logic [AW-1:0] s, logic [AW-1:0] md, logic mw,
                                           logic [AW-1:0] wd, logic ww);
    if (s == 0) return 2'b00;
    if (mw && md == s) return 2'b10;
    if (ww && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic drive(logic [AW-1:0] sa, logic [AW-1:0] sb, logic [AW-1:0] md, logic mw,
                       logic [AW-1:0] wd, logic ww, logic [AW-1:0] xd, logic xl,
                       logic [AW-1:0] da, logic [AW-1:0] db);
    @(negedge clk);
    ex_src_a = sa; ex_src_b = sb; mem_dst = md; mem_wen = mw;
    wb_dst = wd; wb_wen = ww; dx_dst = xd; dx_is_load = xl;
    dec_src_a = da; dec_src_b = db;
    #1;
  endtask

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_idle();
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R6 idle sel_a", {2'b0, fwd_sel_a}, 4'b0000);
    check("R6 idle sel_b", {2'b0, fwd_sel_b}, 4'b0000);
    check("R9 idle stall", {3'b0, stall_req}, 4'b0000);
  endtask

  task automatic t_mem_hit();
    drive(3, 5, 3, 1, 6, 1, 0, 0, 1, 2);
    check("R1 mem hit a", {2'b0, fwd_sel_a}, 4'b0010);
    check("R6 no hit b", {2'b0, fwd_sel_b}, 4'b0000);
  endtask

  task automatic t_wb_hit();
    drive(2, 6, 3, 1, 6, 1, 0, 0, 1, 1);
    check("R2 wb hit b", {2'b0, fwd_sel_b}, 4'b0001);
    check("R6 no hit a", {2'b0, fwd_sel_a}, 4'b0000);
  endtask

  task automatic t_priority();
    drive(4, 4, 4, 1, 4, 1, 0, 0, 1, 1);
    check("R3 prio a", {2'b0, fwd_sel_a}, 4'b0010);
    check("R3 prio b", {2'b0, fwd_sel_b}, 4'b0010);
  endtask

  task automatic t_zero_reg();
    drive(0, 0, 0, 1, 0, 1, 0, 0, 1, 1);
    check("R4 r0 a", {2'b0, fwd_sel_a}, 4'b0000);
    check("R4 r0 b", {2'b0, fwd_sel_b}, 4'b0000);
  endtask

  task automatic t_wen_clear();
    drive(5, 7, 5, 0, 7, 0, 0, 0, 1, 1);
    check("R5 mem wen clear", {2'b0, fwd_sel_a}, 4'b0000);
    check("R5 wb wen clear", {2'b0, fwd_sel_b}, 4'b0000);
    drive(5, 5, 5, 0, 5, 1, 0, 0, 1, 1);
    check("R5 fall to wb", {2'b0, fwd_sel_a}, 4'b0001);
  endtask

  task automatic t_independent();
    drive(3, 6, 3, 1, 6, 1, 0, 0, 1, 1);
    check("R7 a from mem", {2'b0, fwd_sel_a}, 4'b0010);
    check("R7 b from wb", {2'b0, fwd_sel_b}, 4'b0001);
  endtask

  task automatic t_load_use();
    drive(1, 1, 0, 0, 0, 0, 4, 1, 4, 2);
    check("R8 load match src a", {3'b0, stall_req}, 4'b0001);
    drive(1, 1, 0, 0, 0, 0, 4, 1, 2, 4);
    check("R8 load match src b", {3'b0, stall_req}, 4'b0001);
    drive(1, 1, 0, 0, 0, 0, 4, 1, 2, 3);
    check("R8 load no match", {3'b0, stall_req}, 4'b0000);
  endtask

  task automatic t_no_load();
    drive(1, 1, 0, 0, 0, 0, 4, 0, 4, 4);
    check("R9 match without load", {3'b0, stall_req}, 4'b0000);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] sa, sb, md, wd, xd, da, db;
      logic mw, ww, xl;
      sa = AW'($urandom); sb = AW'($urandom); md = AW'($urandom); wd = AW'($urandom);
      xd = AW'($urandom); da = AW'($urandom); db = AW'($urandom);
      mw = 1'($urandom); ww = 1'($urandom); xl = 1'($urandom);
      drive(sa, sb, md, mw, wd, ww, xd, xl, da, db);
      check("R1 R2 R3 R4 R5 sweep a", {2'b0, fwd_sel_a}, {2'b0, model_sel(sa, md, mw, wd, ww)});
      check("R7 sweep b", {2'b0, fwd_sel_b}, {2'b0, model_sel(sb, md, mw, wd, ww)});
      check("R8 R9 sweep stall", {3'b0, stall_req}, {3'b0, xl && (da == xd || db == xd)});
    end
  endtask

  initial begin
    ex_src_a = 0; ex_src_b = 0; mem_dst = 0; wb_dst = 0; dx_dst = 0;
    dec_src_a = 0; dec_src_b = 0; mem_wen = 0; wb_wen = 0; dx_is_load = 0;
    void'($urandom(32'd1234));
    t_idle();
    t_mem_hit();
    t_wb_hit();
    t_priority();
    t_zero_reg();
    t_wen_clear();
    t_independent();
    t_load_use();
    t_no_load();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule